// File: doc/BRIEF.md
# Packed Rounding and Saturating Shifter

This unit shifts every lane of a 32-bit packed word by one common amount. The register index that comes with the operand fixes the lane layout: four 8-bit lanes or two 16-bit lanes. It also fixes whether the lanes hold signed or unsigned values. A 2-bit opcode picks arithmetic right, logical right or logical left shifting. The shift amount comes either from a 4-bit immediate or from the lowest lane of a second register word.

The low bit of a 2-bit mode field changes how each shift behaves. A right shift rounds to nearest: the last bit shifted out is added back to the result. A left shift saturates: a lane whose value cannot be represented after the shift is clamped to its largest or smallest value. Outputs are registered, so each accepted word produces exactly one result one cycle later.

Top module: `packed_shift_unit`

## Requirements
- R1: After reset, `out_valid` and `result` are 0. `out_valid` equals the value `in_valid` had one clock earlier.
- R2: While `in_valid` is low, `result` keeps its previous value, whatever the other inputs do.
- R3: The value of `reg_idx` selects the lane layout:

  | `reg_idx` | Lanes |
  | --- | --- |
  | 2 to 7 | signed 8-bit |
  | 8 to 15 | unsigned 8-bit |
  | 16 to 23 | signed 16-bit |
  | 24 to 29 | unsigned 16-bit |
  | any other value | none: `operand` is copied unchanged to `result` |
- R4: The value of `op` selects the shift:

  | `op` | Shift | Fill |
  | --- | --- | --- |
  | 00 | arithmetic right | lane sign bit |
  | 01 | logical right | zeros |
  | 10 | logical left | zeros |
  | 11 | none: `operand` is copied unchanged | — |
- R5: When `use_imm` is 1 the amount comes from `imm`; otherwise it comes from `amt_word`. Only bits [2:0] (8-bit lanes) or bits [3:0] (16-bit lanes) are used, and the same amount applies to every lane. All other bits of the chosen source are ignored.
- R6: When `mode[0]` is 0, every operation is a plain shift. `mode[1]` has no effect on any operation.
- R7: When `mode[0]` is 1, both right shifts add bit (amount-1) of the original lane to the shifted lane. An amount of 0 returns the lane unchanged.
- R8: When `mode[0]` is 1 and the lanes are signed, a left shift whose result does not fit the lane is clamped. A non-negative lane goes to the largest positive value (0x7F or 0x7FFF). A negative lane goes to the most negative value (0x80 or 0x8000).
- R9: When `mode[0]` is 1 and the lanes are unsigned, a left shift that loses any 1 bit sets the lane to all ones.
- R10: Lanes are independent: no bit crosses from one lane into another.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| operand | input | 32 | Packed word to shift |
| amt_word | input | 32 | Register word that supplies the amount in its lowest lane |
| imm | input | 4 | Immediate shift amount |
| use_imm | input | 1 | 1 takes the amount from `imm`, 0 from `amt_word` |
| reg_idx | input | 5 | Register index that selects lane width and signedness |
| op | input | 2 | Shift opcode |
| mode | input | 2 | Bit 0 enables rounding (right shifts) or saturation (left shifts) |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 32 | Registered shifted word |

## Verification
The hardest cases are at the edge of saturation, where a lane lands exactly on the most negative value without overflowing. An example is -32 shifted left by 2 in an 8-bit lane. A correct design must not clamp that lane, yet its neighbour overflows by a single bit in the same word. The stimulus table packs these near-boundary lanes next to lanes that do overflow, in both 8-bit and 16-bit layouts. It also includes amount sources whose ignored high bits are set, and a mode value with only bit 1 set.

// File: rtl/psu_pkg.sv
package psu_pkg;
   typedef enum logic [1:0] {
      OP_SRA  = 2'b00,
      OP_SRL  = 2'b01,
      OP_SLL  = 2'b10,
      OP_RSVD = 2'b11
   } shift_op_e;
endpackage

// File: rtl/psu_class.sv
module psu_class #(
   parameter int IDX_W     = 5,
   parameter int NS_FIRST  = 2,
   parameter int NS_LAST   = 7,
   parameter int NU_LAST   = 15,
   parameter int WS_FIRST  = 16,
   parameter int WS_LAST   = 23,
   parameter int WU_LAST   = 29
) (
   input  logic [IDX_W-1:0] idx,
   output logic             legal,
   output logic             narrow,
   output logic             is_signed
);
   if (!(NS_FIRST <= NS_LAST && NS_LAST < NU_LAST && NU_LAST < WS_FIRST
         && WS_FIRST <= WS_LAST && WS_LAST < WU_LAST)) begin : g_bad_ranges
      $error("psu_class: index ranges must be ordered and disjoint");
   end
   if (WU_LAST >= (1 << IDX_W)) begin : g_bad_idx_w
      $error("psu_class: index width too small for ranges");
   end

   int unsigned v;
   always_comb begin
      v         = 32'(idx);
      narrow    = (v >= NS_FIRST) && (v <= NU_LAST);
      legal     = narrow || ((v >= WS_FIRST) && (v <= WU_LAST));
      is_signed = ((v >= NS_FIRST) && (v <= NS_LAST))
               || ((v >= WS_FIRST) && (v <= WS_LAST));
   end
endmodule

// File: rtl/psu_lane.sv
module psu_lane
   import psu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0]         x,
   input  logic [$clog2(W)-1:0] sh,
   input  shift_op_e            op,
   input  logic                 rnd_sat,
   input  logic                 is_signed,
   output logic [W-1:0]         y
);
   localparam int SH_W = $clog2(W);
   localparam int DW   = 2 * W;

   if (W < 2 || (1 << SH_W) != W) begin : g_bad_w
      $error("psu_lane: lane width must be a power of two");
   end

   logic [DW-1:0] rfill, rsh, lext, lsh;
   logic [W:0]    tap;
   logic          rbit, ovf;
   logic [W-1:0]  rres, lres, clamp;

   always_comb begin
      // right path: fill chosen by opcode
      rfill = (op == OP_SRA) ? {{W{x[W-1]}}, x} : {{W{1'b0}}, x};
      rsh   = rfill >> sh;
      tap   = {x, 1'b0} >> sh;
      rbit  = tap[0];
      rres  = rsh[W-1:0] + {{(W-1){1'b0}}, rnd_sat & rbit};

      // left path: widened so lost bits remain visible
      lext  = is_signed ? {{W{x[W-1]}}, x} : {{W{1'b0}}, x};
      lsh   = lext << sh;
      if (is_signed) begin
         ovf   = lsh[DW-1:W-1] != {(W+1){x[W-1]}};
         clamp = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      end else begin
         ovf   = lsh[DW-1:W] != '0;
         clamp = '1;
      end
      lres = (rnd_sat && ovf) ? clamp : lsh[W-1:0];

      case (op)
         OP_SRA, OP_SRL: y = rres;
         OP_SLL:         y = lres;
         default:        y = x;
      endcase
   end

   // R8
   always_comb begin
      if (rnd_sat && op == OP_SLL && is_signed)
         sat_sign_chk: assert (y[W-1] == x[W-1])
            else $error("signed saturating shift changed lane sign");
   end

   // R9
   always_comb begin
      if (rnd_sat && op == OP_SLL && !is_signed)
         usat_grow_chk: assert (y >= x)
            else $error("unsigned saturating shift shrank lane");
   end
endmodule

// File: rtl/packed_shift_unit.sv
module packed_shift_unit
   import psu_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16,
   parameter int IDX_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] operand,
   input  logic [WORD_W-1:0] amt_word,
   input  logic [3:0]        imm,
   input  logic              use_imm,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [1:0]        op,
   input  logic [1:0]        mode,
   output logic              out_valid,
   output logic [WORD_W-1:0] result
);
   localparam int N_NARROW = WORD_W / NARROW_W;
   localparam int N_WIDE   = WORD_W / WIDE_W;
   localparam int NSH_W    = $clog2(NARROW_W);
   localparam int WSH_W    = $clog2(WIDE_W);

   if (WORD_W % WIDE_W != 0 || WIDE_W % NARROW_W != 0) begin : g_bad_split
      $error("packed_shift_unit: lane widths must divide the word");
   end
   if (WSH_W > 4) begin : g_bad_imm
      $error("packed_shift_unit: immediate too narrow for wide lanes");
   end

   logic      cls_legal, cls_narrow, cls_signed;
   shift_op_e op_e;
   logic      op_legal;
   logic [WORD_W-1:0] amt_src;
   logic [NSH_W-1:0]  sh_n;
   logic [WSH_W-1:0]  sh_w;
   logic [WORD_W-1:0] word_n, word_w, result_d;

   psu_class #(.IDX_W(IDX_W)) u_class (
      .idx       (reg_idx),
      .legal     (cls_legal),
      .narrow    (cls_narrow),
      .is_signed (cls_signed)
   );

   always_comb begin
      op_e     = shift_op_e'(op);
      op_legal = (op_e != OP_RSVD);
      amt_src  = use_imm ? {{(WORD_W-4){1'b0}}, imm} : amt_word;
      sh_n     = amt_src[NSH_W-1:0];
      sh_w     = amt_src[WSH_W-1:0];
   end

   for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow
      psu_lane #(.W(NARROW_W)) u_lane (
         .x         (operand[i*NARROW_W +: NARROW_W]),
         .sh        (sh_n),
         .op        (op_e),
         .rnd_sat   (mode[0]),
         .is_signed (cls_signed),
         .y         (word_n[i*NARROW_W +: NARROW_W])
      );
   end

   for (genvar j = 0; j < N_WIDE; j++) begin : g_wide
      psu_lane #(.W(WIDE_W)) u_lane (
         .x         (operand[j*WIDE_W +: WIDE_W]),
         .sh        (sh_w),
         .op        (op_e),
         .rnd_sat   (mode[0]),
         .is_signed (cls_signed),
         .y         (word_w[j*WIDE_W +: WIDE_W])
      );
   end

   always_comb begin
      if (!(cls_legal && op_legal)) result_d = operand;
      else if (cls_narrow)          result_d = word_n;
      else                          result_d = word_w;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= result_d;
      end
   end

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R1
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   // R7
   zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && use_imm && imm == 4'd0) |=> result == $past(operand));
endmodule

// File: tb/test_packed_shift_unit.sv
module test_packed_shift_unit;
   localparam int CLK_P = 10;
   localparam int NV    = 20;

   typedef struct packed {
      logic [4:0]  idx;
      logic [1:0]  op;
      logic [1:0]  mode;
      logic        ui;
      logic [3:0]  imm;
      logic [31:0] amt;
      logic [31:0] a;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VECS [0:NV-1] = '{
      '{5'd2,  2'b00, 2'b00, 1'b1, 4'd2,  32'h0,        32'h8040F307, 32'hE010FC01, 4'd4},  // R4 SRA s8
      '{5'd9,  2'b01, 2'b00, 1'b1, 4'd3,  32'h0,        32'h80FF1209, 32'h101F0201, 4'd4},  // R4 SRL u8
      '{5'd3,  2'b10, 2'b00, 1'b0, 4'd0,  32'hFFFFFFF9, 32'h81407F01, 32'h0280FE02, 4'd5},  // R5 reg amt
      '{5'd16, 2'b00, 2'b00, 1'b1, 4'd4,  32'h0,        32'h80001234, 32'hF8000123, 4'd3},  // R3 s16
      '{5'd25, 2'b01, 2'b00, 1'b1, 4'd15, 32'h0,        32'h8000FFFF, 32'h00010001, 4'd3},  // R3 u16
      '{5'd4,  2'b00, 2'b01, 1'b1, 4'd1,  32'h0,        32'h03FD7F80, 32'h02FF40C0, 4'd7},  // R7 round s8
      '{5'd26, 2'b01, 2'b01, 1'b1, 4'd4,  32'h0,        32'h0018FFFF, 32'h00021000, 4'd7},  // R7 round u16
      '{5'd5,  2'b00, 2'b01, 1'b1, 4'd0,  32'h0,        32'h8137C5A9, 32'h8137C5A9, 4'd7},  // R7 zero amt
      '{5'd6,  2'b10, 2'b01, 1'b1, 4'd2,  32'h0,        32'h201FE0DF, 32'h7F7C8080, 4'd8},  // R8 s8 edge
      '{5'd12, 2'b10, 2'b01, 1'b1, 4'd3,  32'h0,        32'h1F200100, 32'hF8FF0800, 4'd9},  // R9 u8
      '{5'd20, 2'b10, 2'b01, 1'b0, 4'd0,  32'hABCD0003, 32'h0FFFF000, 32'h7FF88000, 4'd8},  // R8 s16 edge
      '{5'd18, 2'b10, 2'b01, 1'b1, 4'd1,  32'h0,        32'h4000BFFF, 32'h7FFF8000, 4'd8},  // R8 s16 clamp
      '{5'd29, 2'b10, 2'b01, 1'b1, 4'd15, 32'h0,        32'h00010002, 32'h8000FFFF, 4'd9},  // R9 u16
      '{5'd7,  2'b10, 2'b10, 1'b1, 4'd1,  32'h0,        32'h804100FF, 32'h008200FE, 4'd6},  // R6 bit1 only
      '{5'd7,  2'b10, 2'b11, 1'b1, 4'd1,  32'h0,        32'h804100FF, 32'h807F00FE, 4'd6},  // R6 mode 11
      '{5'd30, 2'b00, 2'b00, 1'b1, 4'd3,  32'h0,        32'hDEADBEEF, 32'hDEADBEEF, 4'd3},  // R3 idx 30
      '{5'd1,  2'b01, 2'b00, 1'b1, 4'd3,  32'h0,        32'hCAFEF00D, 32'hCAFEF00D, 4'd3},  // R3 idx 1
      '{5'd2,  2'b11, 2'b00, 1'b1, 4'd3,  32'h0,        32'h12345678, 32'h12345678, 4'd4},  // R4 op 11
      '{5'd8,  2'b01, 2'b00, 1'b1, 4'd9,  32'h0,        32'hF0F0F0F0, 32'h78787878, 4'd5},  // R5 imm high bit
      '{5'd2,  2'b00, 2'b00, 1'b1, 4'd7,  32'h0,        32'h807FFF01, 32'hFF00FF00, 4'd10}  // R10 lanes
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] operand = '0;
   logic [31:0] amt_word = '0;
   logic [3:0]  imm = '0;
   logic        use_imm = 1'b0;
   logic [4:0]  reg_idx = '0;
   logic [1:0]  op = '0;
   logic [1:0]  mode = '0;
   logic        out_valid;
   logic [31:0] result;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   packed_shift_unit i_packed_shift_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
      .amt_word(amt_word), .imm(imm), .use_imm(use_imm), .reg_idx(reg_idx),
      .op(op), .mode(mode), .out_valid(out_valid), .result(result)
   );

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {31'b0, out_valid}, 32'h0);
      check("R1", result, 32'h0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         reg_idx  = VECS[k].idx;
         op       = VECS[k].op;
         mode     = VECS[k].mode;
         use_imm  = VECS[k].ui;
         imm      = VECS[k].imm;
         amt_word = VECS[k].amt;
         operand  = VECS[k].a;
         in_valid = 1'b1;
         @(negedge clk);
         check($sformatf("R%0d vec %0d", VECS[k].req, k), result, VECS[k].exp);
         check("R1 valid", {31'b0, out_valid}, 32'h1);
         in_valid = 1'b0;
      end

      // R2: inputs change while idle, result must hold
      @(negedge clk);
      operand = 32'h11111111; reg_idx = 5'd9; op = 2'b10; imm = 4'd1;
      @(negedge clk);
      check("R2 hold", result, 32'hFF00FF00);
      check("R1 drop", {31'b0, out_valid}, 32'h0);

      // R5: amount from register while immediate is ignored
      use_imm = 1'b0; imm = 4'd7; amt_word = 32'hFFFF0001;
      reg_idx = 5'd24; op = 2'b01; mode = 2'b00; operand = 32'h80008000;
      in_valid = 1'b1;
      @(negedge clk);
      check("R5 reg source", result, 32'h40004000);
      in_valid = 1'b0;

      // R1: synchronous reset clears the output
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset", result, 32'h0);
      check("R1 reset valid", {31'b0, out_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule